// File: doc/BRIEF.md
# Banked Multi-Port Register File

This block is a shared register file for several clients that each own a private region of storage. There is one bank for each write port. Each bank is a power-of-two number of words deep and has its own word width. The banks are laid end to end to form one global address space. A client writes only into its own bank, using a short local address. Every read port can fetch any word in the global space, using a longer global address. Each bank holds one replica of its storage for each read port, and every write updates all replicas of that bank. The read ports therefore never compete with each other.

A read is synchronous. The address presented at a rising edge produces data after that edge. The bank is chosen by the upper read-address bits, at the granularity of the smallest bank. That choice is registered with the memory output and steers a one-hot OR multiplexer. Narrow banks come out zero-extended to the widest bank width. Bank heights must be given in non-increasing order so that every bank starts on a multiple of its own height. The low bits of a global address are then exactly the local address inside the bank.

Default configuration: three banks with log2 heights {3,2,1}, so heights {8,4,2}, and widths {16,8,12}. There are two read ports. The global height is 14, the read address is 4 bits and the read data is 16 bits. The write-address slot is 3 bits per bank and the write-data slot is 16 bits per bank.

Top module: `banked_regfile`

## Requirements
- R1: Bank i covers global addresses from the sum of the heights of banks 0..i-1 upward, for its own height. With the defaults, bank 0 covers 0–7, bank 1 covers 8–11 and bank 2 covers 12–13.
- R2: Write port i uses slot bits [i*3 +: 3] of `wr_addr`, and only the low log2(height) bits of that slot. A write at local address a lands at global address base(i)+a. The upper slot bits are ignored.
- R3: A read has one cycle of latency. The data for the address sampled at a rising edge appears on `rd_data` after that edge and holds until the next edge.
- R4: When a read and a write target the same word in the same cycle, the read returns the value from before the write.
- R5: Read port p uses `rd_addr[p*4 +: 4]` and drives `rd_data[p*16 +: 16]`. All read ports work at the same time and independently, on any addresses.
- R6: A word read from a bank narrower than the output has zeros in every bit at or above that bank's width.
- R7: A read address at or above the global height (14 or 15 by default) returns zero.
- R8: While reset is held, and after its release until the first read edge, `rd_data` is zero.
- R9: A write port with its enable low changes no stored word.
- R10: All write ports can write in the same cycle, each into its own bank, and every one of those writes takes effect.
- R11: Write port i uses the low width(i) bits of slot `wr_data[i*16 +: 16]`. The other bits of that slot are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read-select state |
| wr_en | input | NUM_BANKS (3) | Write enable, one bit per bank |
| wr_addr | input | NUM_BANKS*MAXAW (9) | Local write address slots, one per bank |
| wr_data | input | NUM_BANKS*RW (48) | Write data slots, one per bank |
| rd_addr | input | NUM_RD*RAW (8) | Global read addresses, one per read port |
| rd_data | output | NUM_RD*RW (32) | Read data, one per read port |

## Verification
The bench reads every address on both ports at once, in opposite orders. A wrong bank base or a wrong select granularity would then return a neighbouring bank's word, and a missing replica would corrupt one port when the other moves. It writes and reads one word in the same cycle to catch a write-first memory, which would return the new value early. It also writes with set upper address and data bits, to catch a slot decoded too wide, which would hit another word or leak data above a narrow bank's width. It reads the two addresses past the top of the space, where a design that ignored the range would alias into bank 0.

// File: rtl/regfile_cfg_pkg.sv
package regfile_cfg_pkg;

    localparam int MAX_BANKS = 8;

    typedef int cfg_t [MAX_BANKS];

    // Global start of bank idx: sum of heights of all lower banks.
    function automatic int bank_base(cfg_t lh, int idx);
        int s;
        s = 0;
        for (int j = 0; j < MAX_BANKS; j++) begin
            if (j < idx) s += (1 << lh[j]);
        end
        return s;
    endfunction

    function automatic int max_of(cfg_t v, int n);
        int m;
        m = v[0];
        for (int j = 1; j < MAX_BANKS; j++) begin
            if (j < n && v[j] > m) m = v[j];
        end
        return m;
    endfunction

    function automatic int min_of(cfg_t v, int n);
        int m;
        m = v[0];
        for (int j = 1; j < MAX_BANKS; j++) begin
            if (j < n && v[j] < m) m = v[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/rf_bank_copy.sv
module rf_bank_copy #(
    parameter int AW = 3,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Read-first: the read sees the word before this edge's write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
    parameter int AW  = 3,
    parameter int W   = 16,
    parameter int NRD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*W-1:0]  rdata
);
    for (genvar p = 0; p < NRD; p++) begin : g_copy
        rf_bank_copy #(.AW(AW), .W(W)) i_copy (
            .clk   (clk),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[p*AW +: AW]),
            .rdata (rdata[p*W +: W])
        );
    end

    // Replicas of one bank must agree when read at the same word.
    for (genvar p = 1; p < NRD; p++) begin : g_agree
        AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            (raddr[p*AW +: AW] == raddr[0 +: AW]) |=> (rdata[p*W +: W] == rdata[0 +: W])); // R5
    end

endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel
    import regfile_cfg_pkg::*;
#(
    parameter int   NUM_BANKS = 3,
    parameter int   RAW       = 4,
    parameter int   RW        = 16,
    parameter int   SEL_LSB   = 1,
    parameter int   TOTAL_H   = 14,
    parameter cfg_t BANK_LH   = '{3, 2, 1, 1, 1, 1, 1, 1},
    parameter cfg_t BANK_W    = '{16, 8, 12, 1, 1, 1, 1, 1}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [RAW-1:0]          raddr,
    input  logic [NUM_BANKS*RW-1:0] bank_dout,
    output logic [RW-1:0]           rd_data
);
    localparam int SELW = RAW - SEL_LSB;

    logic [SELW-1:0]      chunk;
    logic [NUM_BANKS-1:0] hit_d;
    logic [NUM_BANKS-1:0] hit_q;
    logic                 unused_raddr_lo;

    assign chunk           = raddr[RAW-1:SEL_LSB];
    assign unused_raddr_lo = ^raddr[SEL_LSB-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        localparam int LO = bank_base(BANK_LH, b) >> SEL_LSB;
        localparam int HI = bank_base(BANK_LH, b + 1) >> SEL_LSB;
        assign hit_d[b] = (int'(chunk) >= LO) && (int'(chunk) < HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hit_q <= '0;
        else        hit_q <= hit_d;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_q[b]) rd_data = rd_data | bank_dout[b*RW +: RW];
        end
    end

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_q)); // R1
    AST_INRANGE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(raddr) < TOTAL_H) |=> (hit_q != '0)); // R1
    AST_OUT_OF_RANGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(raddr) >= TOTAL_H) |=> (rd_data == '0)); // R7

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_narrow
        localparam int BW = BANK_W[b];
        AST_NARROW_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
            hit_q[b] |-> ((rd_data >> BW) == '0)); // R6
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regfile_cfg_pkg::*;
#(
    parameter int   NUM_BANKS = 3,
    parameter int   NUM_RD    = 2,
    parameter cfg_t BANK_LH   = '{3, 2, 1, 1, 1, 1, 1, 1},
    parameter cfg_t BANK_W    = '{16, 8, 12, 1, 1, 1, 1, 1},
    localparam int  TOTAL_H   = bank_base(BANK_LH, NUM_BANKS),
    localparam int  RAW       = $clog2(TOTAL_H),
    localparam int  RW        = max_of(BANK_W, NUM_BANKS),
    localparam int  MAXAW     = max_of(BANK_LH, NUM_BANKS),
    localparam int  SEL_LSB   = min_of(BANK_LH, NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS-1:0]       wr_en,
    input  logic [NUM_BANKS*MAXAW-1:0] wr_addr,
    input  logic [NUM_BANKS*RW-1:0]    wr_data,
    input  logic [NUM_RD*RAW-1:0]      rd_addr,
    output logic [NUM_RD*RW-1:0]       rd_data
);
    // Per read port: all banks' outputs, each zero-extended to RW.
    logic [NUM_BANKS*RW-1:0] bank_bus [NUM_RD];
    logic                    unused_wr_bits;

    assign unused_wr_bits = ^{wr_addr, wr_data};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int AW = BANK_LH[b];
        localparam int WB = BANK_W[b];

        logic [NUM_RD*AW-1:0] lraddr;
        logic [NUM_RD*WB-1:0] lrdata;

        for (genvar p = 0; p < NUM_RD; p++) begin : g_port
            assign lraddr[p*AW +: AW]       = rd_addr[p*RAW +: AW];
            assign bank_bus[p][b*RW +: RW] = RW'(lrdata[p*WB +: WB]);
        end

        rf_bank #(.AW(AW), .W(WB), .NRD(NUM_RD)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en[b]),
            .waddr (wr_addr[b*MAXAW +: AW]),
            .wdata (wr_data[b*RW +: WB]),
            .raddr (lraddr),
            .rdata (lrdata)
        );
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_sel #(
            .NUM_BANKS (NUM_BANKS),
            .RAW       (RAW),
            .RW        (RW),
            .SEL_LSB   (SEL_LSB),
            .TOTAL_H   (TOTAL_H),
            .BANK_LH   (BANK_LH),
            .BANK_W    (BANK_W)
        ) i_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .raddr     (rd_addr[p*RAW +: RAW]),
            .bank_dout (bank_bus[p]),
            .rd_data   (rd_data[p*RW +: RW])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0)); // R8

endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  wr_en = '0;
    logic [8:0]  wr_addr = '0;
    logic [47:0] wr_data = '0;
    logic [7:0]  rd_addr = 8'hFF;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    banked_regfile i_banked_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Layout from R1, widths from R6/R11.
    int base_g [3] = '{0, 8, 12};
    int hgt_g  [3] = '{8, 4, 2};
    int wid_g  [3] = '{16, 8, 12};

    logic [15:0] mdl [16];

    typedef struct {
        int          due;
        int          port;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb [$];

    int checks = 0;
    int fails  = 0;
    int pcnt   = 0;
    bit done   = 0;

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: drives one cycle of stimulus, pushes expected reads, updates model.
    task automatic step(logic [2:0] we, logic [2:0] a0, logic [2:0] a1, logic [2:0] a2,
                        logic [15:0] d0, logic [15:0] d1, logic [15:0] d2,
                        logic [3:0] r0, logic [3:0] r1, bit chk, string req);
        logic [2:0]  aa [3];
        logic [15:0] dd [3];
        item_t it;
        @(negedge clk);
        wr_en   = we;
        wr_addr = {a2, a1, a0};
        wr_data = {d2, d1, d0};
        rd_addr = {r1, r0};
        if (chk) begin
            it.due = pcnt + 1; it.req = req;
            it.port = 0; it.exp = mdl[r0]; sb.push_back(it);
            it.port = 1; it.exp = mdl[r1]; sb.push_back(it);
        end
        aa[0] = a0; aa[1] = a1; aa[2] = a2;
        dd[0] = d0; dd[1] = d1; dd[2] = d2;
        for (int i = 0; i < 3; i++) begin
            if (we[i]) begin
                mdl[base_g[i] + (int'(aa[i]) & (hgt_g[i] - 1))] =
                    dd[i] & 16'((32'd1 << wid_g[i]) - 1);
            end
        end
    endtask

    // Monitor: compares results just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            pcnt++;
            #1;
            while (sb.size() > 0 && sb[0].due == pcnt) begin
                item_t it;
                it = sb.pop_front();
                check($sformatf("%s port%0d", it.req, it.port),
                      rd_data[it.port*16 +: 16], it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R8 reset port0", rd_data[15:0], 16'h0);
        check("R8 reset port1", rd_data[31:16], 16'h0);
        rst_n = 1'b1;
        check("R8 after release port0", rd_data[15:0], 16'h0);
        check("R8 after release port1", rd_data[31:16], 16'h0);

        // R10: all banks written together; R7: reads past the top return zero.
        for (int k = 0; k < 8; k++) begin
            step({k < 2, k < 4, 1'b1}, 3'(k), 3'(k), 3'(k),
                 16'h1000 + 16'(k) * 16'h0111, 16'hA5C0 + 16'(k), 16'hF000 | (16'(k) * 16'h0123),
                 4'd14, 4'd15, 1'b1, "R7 R10");
        end

        // R1 R3 R5 R6 R11: full sweep, both ports in opposite orders.
        for (int g = 0; g < 16; g++) begin
            step(3'b000, 3'd0, 3'd0, 3'd0, 16'h0, 16'h0, 16'h0,
                 4'(g), 4'(15 - g), 1'b1, "R1 R3 R5 R6 R11");
        end

        // R9: disabled write leaves words untouched.
        step(3'b000, 3'd0, 3'd1, 3'd0, 16'hDEAD, 16'hBEEF, 16'hCAFE, 4'd0, 4'd9, 1'b0, "");
        step(3'b000, 3'd0, 3'd0, 3'd0, 16'h0, 16'h0, 16'h0, 4'd0, 4'd9, 1'b1, "R9");

        // R4: same-cycle read of the written word returns old data, then new.
        step(3'b001, 3'd3, 3'd0, 3'd0, 16'h7777, 16'h0, 16'h0, 4'd3, 4'd3, 1'b1, "R4 old");
        step(3'b000, 3'd0, 3'd0, 3'd0, 16'h0, 16'h0, 16'h0, 4'd3, 4'd11, 1'b1, "R4 new");

        // R2: upper slot bits ignored; bank1 slot 6 -> global 10, bank2 slot 5 -> global 13.
        step(3'b110, 3'd0, 3'd6, 3'd5, 16'h0, 16'h1234, 16'h0ABC, 4'd14, 4'd14, 1'b0, "");
        step(3'b000, 3'd0, 3'd0, 3'd0, 16'h0, 16'h0, 16'h0, 4'd13, 4'd12, 1'b1, "R2 bank2");
        step(3'b000, 3'd0, 3'd0, 3'd0, 16'h0, 16'h0, 16'h0, 4'd10, 4'd8, 1'b1, "R2 bank1");

        step(3'b000, 3'd0, 3'd0, 3'd0, 16'h0, 16'h0, 16'h0, 4'd15, 4'd14, 1'b0, "");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule